// File: doc/BRIEF.md
# Multidrop Nine-Bit Serial Receiver

This block receives asynchronous serial characters from a shared RS485-style bus where several nodes listen on one pair of wires. The bit slot that a plain UART would fill with parity instead carries a ninth bit. A one there marks the character as an address, and a zero marks it as data. Each character has 5 to 8 data bits, picked by a two-bit length code, and the line is sampled on a 16x oversampling strike.

The block runs a hardware address filter, so software does not have to look at every data byte on the bus. The data gate starts closed, and the receiver then drops data characters. Every address character is still stored and raises a one-cycle wake strobe. The gate opens when an address equals the node address or the broadcast address. It closes again on any other address, including the terminator code. Received characters go into a small show-ahead FIFO. Each FIFO entry carries an address flag and a framing-error flag, and a sticky overrun flag records any push that arrived while the FIFO was full. A synchronous receiver-reset command clears all of this state.

Top module: `mdrop_rx`

## Requirements
- R1: `len_sel` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data arrives least significant bit first after a low start bit. It appears on `rd_data` zero-extended to 8 bits.
- R2: The bit that follows the last data bit is the address tag. `rd_is_addr` shows it for the entry at the head of the FIFO.
- R3: Every address character is written to the FIFO whatever the gate state. Each one produces exactly one single-cycle `wake` pulse, and data characters produce none.
- R4: An address equal to `node_addr` or to the broadcast code 0xFE opens the data gate. Data characters are stored only while the gate is open.
- R5: An address that matches neither the node address nor the broadcast code closes the gate, and the data characters after it are dropped.
- R6: An address character of value 0xFF is the terminator. It is stored as an address entry, closes the gate, and the data after it is dropped.
- R7: If the stop bit is sampled low, `rd_ferr` is set on that entry. The receiver waits for the line to return high before it looks for a new start bit.
- R8: A character that would be stored while the FIFO holds `FIFO_DEPTH` entries is discarded. `overrun` then sets and stays set, and the earlier entries are kept.
- R9: `rd_ready` is high exactly when the FIFO is not empty. Asserting `rd_en` while `rd_ready` is high removes the head entry, and entries leave in arrival order.
- R10: A one-cycle `rx_reset` empties the FIFO, clears `overrun`, closes the gate and abandons any character in progress.
- R11: A low pulse on the line that is high again before the middle of the start bit is discarded without storing anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | Oversampling strobe, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| len_sel | input | 2 | Data-bit count code (0 to 3 means 5 to 8 bits) |
| node_addr | input | 8 | This node's address |
| rx_reset | input | 1 | Synchronous receiver reset command |
| rd_en | input | 1 | Pop the head FIFO entry |
| rd_data | output | 8 | Head entry data bits, zero-extended |
| rd_is_addr | output | 1 | Head entry is an address character |
| rd_ferr | output | 1 | Head entry had a framing error |
| rd_ready | output | 1 | FIFO not empty |
| wake | output | 1 | One-cycle strobe per address character received |
| overrun | output | 1 | Sticky flag for a store attempted into a full FIFO |

## Verification
The data path is swept with every value at lengths 5, 6 and 7, and with every third value at length 8, each after a matching address. This catches bit-order, zero-extension and tag-position errors for each length code. Address sweeps go through non-matching, broadcast and terminator codes, each followed by a data character, so a gate that opens or closes on the wrong compare shows up as an extra or missing entry. Separate patterns cover a low stop bit, a burst that overfills the FIFO, a reset in the middle of a message and a short glitch on the line. Each of these tells apart one of the flag paths or the start-bit qualification.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;

  localparam int CHAR_W = 8;

  typedef struct packed {
    logic              ferr;
    logic              is_addr;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_TAG,
    S_STOP,
    S_WAIT
  } rx_state_e;

  function automatic logic [3:0] bits_for_code(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

endpackage

// File: rtl/mdrop_rx_sampler.sv
module mdrop_rx_sampler
  import mdrop_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  logic      tick,
  input  logic      rxd,
  input  logic [1:0] len_code,
  output logic      out_valid,
  output rx_entry_t out_entry
);

  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);

  logic rx_m, rx_s;
  rx_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [2:0] idx_q, idx_d;
  logic [1:0] len_q, len_d;
  logic [CHAR_W-1:0] shr_q, shr_d;
  logic tag_q, tag_d;
  logic valid_q, valid_d;
  rx_entry_t entry_q, entry_d;
  logic [2:0] last_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
    end
  end

  assign last_idx = 3'(bits_for_code(len_q) - 4'd1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    len_d   = len_q;
    shr_d   = shr_q;
    tag_d   = tag_q;
    entry_d = entry_q;
    valid_d = 1'b0;
    if (flush) begin
      state_d = S_IDLE;
      cnt_d   = '0;
    end else if (tick) begin
      unique case (state_q)
        S_IDLE: begin
          if (!rx_s) begin
            state_d = S_START;
            cnt_d   = '0;
            len_d   = len_code;
          end
        end
        S_START: begin
          if (cnt_q == MID_CNT) begin
            cnt_d = '0;
            if (!rx_s) begin
              state_d = S_DATA;
              idx_d   = '0;
              shr_d   = '0;
            end else begin
              state_d = S_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_DATA: begin
          if (cnt_q == LAST_CNT) begin
            cnt_d        = '0;
            shr_d[idx_q] = rx_s;
            if (idx_q == last_idx) state_d = S_TAG;
            else                   idx_d   = idx_q + 3'd1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_TAG: begin
          if (cnt_q == LAST_CNT) begin
            cnt_d   = '0;
            tag_d   = rx_s;
            state_d = S_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_STOP: begin
          if (cnt_q == LAST_CNT) begin
            cnt_d           = '0;
            valid_d         = 1'b1;
            entry_d.ferr    = ~rx_s;
            entry_d.is_addr = tag_q;
            entry_d.data    = shr_q;
            state_d         = S_WAIT;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_WAIT: begin
          if (rx_s) state_d = S_IDLE;
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      len_q   <= '0;
      shr_q   <= '0;
      tag_q   <= 1'b0;
      valid_q <= 1'b0;
      entry_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      len_q   <= len_d;
      shr_q   <= shr_d;
      tag_q   <= tag_d;
      valid_q <= valid_d;
      entry_q <= entry_d;
    end
  end

  assign out_valid = valid_q;
  assign out_entry = entry_q;

endmodule

// File: rtl/mdrop_rx_filter.sv
module mdrop_rx_filter
  import mdrop_rx_pkg::*;
#(
  parameter logic [CHAR_W-1:0] BCAST_ADDR = 8'hFE,
  parameter logic [CHAR_W-1:0] TERM_CODE  = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  input  rx_entry_t         in_entry,
  input  logic [CHAR_W-1:0] node_addr,
  output logic              push,
  output rx_entry_t         push_entry,
  output logic              wake
);

  logic gate_q, gate_d;
  logic push_q, push_d;
  logic wake_q, wake_d;
  rx_entry_t ent_q, ent_d;
  logic hit;

  assign hit = (in_entry.data == node_addr) || (in_entry.data == BCAST_ADDR);

  always_comb begin
    gate_d = gate_q;
    push_d = 1'b0;
    wake_d = 1'b0;
    ent_d  = ent_q;
    if (flush) begin
      gate_d = 1'b0;
    end else if (in_valid) begin
      ent_d = in_entry;
      if (in_entry.is_addr) begin
        push_d = 1'b1;
        wake_d = 1'b1;
        gate_d = hit && (in_entry.data != TERM_CODE);
      end else begin
        push_d = gate_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      push_q <= 1'b0;
      wake_q <= 1'b0;
      ent_q  <= '0;
    end else begin
      gate_q <= gate_d;
      push_q <= push_d;
      wake_q <= wake_d;
      ent_q  <= ent_d;
    end
  end

  assign push       = push_q;
  assign push_entry = ent_q;
  assign wake       = wake_q;

endmodule

// File: rtl/mdrop_rx_fifo.sv
module mdrop_rx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         overrun
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic ovr_q, ovr_d;
  logic full, do_push, do_pop;

  assign full    = (cnt_q == CNT_FULL);
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    ovr_d = ovr_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
      ovr_d = 1'b0;
    end else begin
      if (push && full) ovr_d = 1'b1;
      if (do_push) wr_d = (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_d = (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata;
  end

  assign rdata   = mem[rd_q];
  assign overrun = ovr_q;

endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx
  import mdrop_rx_pkg::*;
#(
  parameter int         OSR        = 16,
  parameter int         FIFO_DEPTH = 4,
  parameter logic [7:0] BCAST_ADDR = 8'hFE,
  parameter logic [7:0] TERM_CODE  = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_tick,
  input  logic       rxd,
  input  logic [1:0] len_sel,
  input  logic [7:0] node_addr,
  input  logic       rx_reset,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       rd_is_addr,
  output logic       rd_ferr,
  output logic       rd_ready,
  output logic       wake,
  output logic       overrun
);

  logic rst_m, rst_n_i;
  logic chr_valid, flt_push, fifo_empty;
  rx_entry_t chr_entry, flt_entry, head;
  logic [ENTRY_W-1:0] head_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m   <= 1'b0;
      rst_n_i <= 1'b0;
    end else begin
      rst_m   <= 1'b1;
      rst_n_i <= rst_m;
    end
  end

  mdrop_rx_sampler #(.OSR(OSR)) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .flush    (rx_reset),
    .tick     (sample_tick),
    .rxd      (rxd),
    .len_code (len_sel),
    .out_valid(chr_valid),
    .out_entry(chr_entry)
  );

  mdrop_rx_filter #(.BCAST_ADDR(BCAST_ADDR), .TERM_CODE(TERM_CODE)) u_filter (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .flush     (rx_reset),
    .in_valid  (chr_valid),
    .in_entry  (chr_entry),
    .node_addr (node_addr),
    .push      (flt_push),
    .push_entry(flt_entry),
    .wake      (wake)
  );

  mdrop_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .flush  (rx_reset),
    .push   (flt_push),
    .wdata  (flt_entry),
    .pop    (rd_en),
    .rdata  (head_bits),
    .empty  (fifo_empty),
    .overrun(overrun)
  );

  assign head       = rx_entry_t'(head_bits);
  assign rd_data    = head.data;
  assign rd_is_addr = head.is_addr;
  assign rd_ferr    = head.ferr;
  assign rd_ready   = !fifo_empty;

endmodule

// File: rtl/mdrop_rx_chk.sv
module mdrop_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_reset,
  input logic wake,
  input logic rd_ready,
  input logic overrun
);

  // R3: a wake strobe goes with a stored entry
  a_r3_wake_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !rx_reset) |=> rd_ready);

  // R3: wake lasts a single cycle
  a_r3_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  // R8: overrun holds until a receiver reset
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !rx_reset) |=> overrun);

  // R8: overrun only rises with a full, hence non-empty, FIFO
  a_r8_overrun_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> rd_ready);

  // R10: receiver reset empties and clears
  a_r10_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset |=> (!rd_ready && !overrun && !wake));

endmodule

bind mdrop_rx mdrop_rx_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rx_reset(rx_reset),
  .wake    (wake),
  .rd_ready(rd_ready),
  .overrun (overrun)
);

// File: tb/mdrop_rx_bench.sv
module mdrop_rx_bench;

  localparam int DEPTH = 4;
  localparam int BIT   = 16;

  logic clk, rst_n, sample_tick, rxd, rx_reset, rd_en;
  logic [1:0] len_sel;
  logic [7:0] node_addr;
  logic [7:0] rd_data;
  logic rd_is_addr, rd_ferr, rd_ready, wake, overrun;

  int n_cmp, n_bad, wake_seen, wake_exp;
  bit done;

  logic [9:0] mq [0:15];
  int mq_cnt;
  bit m_gate, m_ovr;

  mdrop_rx #(.FIFO_DEPTH(DEPTH)) u_mdrop_rx (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rxd(rxd),
    .len_sel(len_sel), .node_addr(node_addr), .rx_reset(rx_reset),
    .rd_en(rd_en), .rd_data(rd_data), .rd_is_addr(rd_is_addr),
    .rd_ferr(rd_ferr), .rd_ready(rd_ready), .wake(wake), .overrun(overrun)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) if (rst_n && wake) wake_seen++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic model_push(input logic [9:0] e);
    if (mq_cnt == DEPTH) m_ovr = 1'b1;
    else begin
      mq[mq_cnt] = e;
      mq_cnt++;
    end
  endtask

  // frame on the wire plus the bench's own expectation
  task automatic send(input int nb, input logic [7:0] v, input logic tag, input logic stop);
    logic [7:0] mv;
    mv = v & 8'((1 << nb) - 1);
    @(negedge clk);
    hold(1'b0, BIT);
    for (int i = 0; i < nb; i++) hold(mv[i], BIT);
    hold(tag, BIT);
    hold(stop, BIT);
    hold(1'b1, 2 * BIT);
    if (tag) begin
      wake_exp++;
      model_push({~stop, 1'b1, mv});
      m_gate = ((mv == node_addr) || (mv == 8'hFE)) && (mv != 8'hFF);
    end else if (m_gate) begin
      model_push({~stop, 1'b0, mv});
    end
  endtask

  task automatic drain(input string req);
    while (mq_cnt > 0) begin
      chk({req, " ready"}, 32'(rd_ready), 32'd1);
      chk({req, " entry"}, {22'd0, rd_ferr, rd_is_addr, rd_data}, {22'd0, mq[0]});
      for (int i = 0; i < 15; i++) mq[i] = mq[i + 1];
      mq_cnt--;
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      @(negedge clk);
    end
    chk({req, " R9 empty after drain"}, 32'(rd_ready), 32'd0);
  endtask

  task automatic do_reset_cmd();
    rx_reset = 1'b1;
    @(negedge clk);
    rx_reset = 1'b0;
    @(negedge clk);
    mq_cnt = 0;
    m_gate = 1'b0;
    m_ovr  = 1'b0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; wake_seen = 0; wake_exp = 0; done = 1'b0;
    mq_cnt = 0; m_gate = 1'b0; m_ovr = 1'b0;
    rst_n = 1'b0; sample_tick = 1'b1; rxd = 1'b1; rx_reset = 1'b0;
    rd_en = 1'b0; len_sel = 2'd3; node_addr = 8'h15;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 reset ready", 32'(rd_ready), 32'd0);
    chk("R8 reset overrun", 32'(overrun), 32'd0);
    chk("R3 reset wake", 32'(wake), 32'd0);

    // R1 R2 R4: sweep each length, data after matching address
    for (int c = 0; c < 4; c++) begin
      int nb;
      nb = 5 + c;
      len_sel = 2'(c);
      send(nb, node_addr, 1'b1, 1'b1);
      drain("R2 addr tag");
      for (int v = 0; v < (1 << nb); v += (nb == 8) ? 3 : 1) begin
        send(nb, 8'(v), 1'b0, 1'b1);
        drain("R1 data sweep");
      end
    end
    chk("R3 wake count sweep", 32'(wake_seen), 32'(wake_exp));

    // R5 R4: non-matching and broadcast addresses, each with one data char
    len_sel = 2'd3;
    for (int a = 0; a < 256; a += 17) begin
      send(8, 8'(a), 1'b1, 1'b1);
      send(8, 8'(a ^ 8'h5A), 1'b0, 1'b1);
      drain("R5 address filter");
    end
    send(8, 8'h33, 1'b1, 1'b1);
    send(8, 8'h5A, 1'b0, 1'b1);
    drain("R5 foreign address");
    send(8, 8'hFE, 1'b1, 1'b1);
    send(8, 8'hA5, 1'b0, 1'b1);
    drain("R4 broadcast");

    // R6: terminator closes the gate
    send(8, node_addr, 1'b1, 1'b1);
    send(8, 8'h66, 1'b0, 1'b1);
    send(8, 8'hFF, 1'b1, 1'b1);
    send(8, 8'h3C, 1'b0, 1'b1);
    drain("R6 terminator");
    chk("R3 wake count filter", 32'(wake_seen), 32'(wake_exp));

    // R7: low stop bit on data and address
    send(8, node_addr, 1'b1, 1'b1);
    send(8, 8'h81, 1'b0, 1'b0);
    send(8, 8'h42, 1'b0, 1'b1);
    send(8, 8'h27, 1'b1, 1'b0);
    drain("R7 framing");

    // R8: overfill
    send(8, node_addr, 1'b1, 1'b1);
    for (int i = 0; i < DEPTH; i++) send(8, 8'(8'hC0 + i), 1'b0, 1'b1);
    chk("R8 overrun set", 32'(overrun), 32'(m_ovr));
    drain("R8 kept entries");
    chk("R8 overrun sticky", 32'(overrun), 32'd1);

    // R10: reset mid-message
    send(8, node_addr, 1'b1, 1'b1);
    send(8, 8'h11, 1'b0, 1'b1);
    chk("R10 before reset ready", 32'(rd_ready), 32'd1);
    do_reset_cmd();
    chk("R10 flush ready", 32'(rd_ready), 32'd0);
    chk("R10 clear overrun", 32'(overrun), 32'd0);
    send(8, 8'h22, 1'b0, 1'b1);
    chk("R10 gate closed", 32'(rd_ready), 32'd0);
    // reset while a character is on the wire
    @(negedge clk);
    hold(1'b0, BIT);
    hold(1'b1, 3);
    do_reset_cmd();
    hold(1'b1, 12 * BIT);
    chk("R10 abandon char", 32'(rd_ready), 32'd0);

    // R11: glitch shorter than half a bit
    hold(1'b0, 4);
    hold(1'b1, 4 * BIT);
    chk("R11 glitch ignored", 32'(rd_ready), 32'd0);
    chk("R3 wake count end", 32'(wake_seen), 32'(wake_exp));

    done = 1'b1;
    summary();
  end

endmodule